// File: doc/BRIEF.md
# Link power status monitor

This block watches the power-status line that a link-layer controller drives toward the physical layer. The line may be a steady level or a pulse train. The block sends the line through a synchronizer and counts how many clock cycles in a row it has been sampled low. From that count it sorts the link into three states:

- **active**: normal operation.
- **reset**: the interface is held quiet, but the PHY clock keeps running.
- **disabled**: the interface is held quiet and the PHY clock enable is also dropped.

The block also gates the PHY-to-link control and data outputs and masks the request input from the link. It produces the link-active bit that goes into self-identification, which is the status line's activity ANDed with a register control bit. When the link wakes from the disabled state, it emits a one-cycle bus-reset request.

Two parameters set the thresholds in clock cycles. At 98.304 MHz, the defaults are 256 cycles (about 2.6 µs) and 2560 cycles (about 26 µs). A pulsed status line whose low times stay below the first threshold is treated as active.

Top module: `link_pwr_mon`

## Requirements
- R1: After the asynchronous reset releases, the state is disabled (`state_o` = 2'b10), `pclk_en_o` is 0, `ctl_o`, `data_o` and `lreq_o` are 0, and `link_active_o` is 0.
- R2: `lps_i` passes through a two-flop synchronizer. The low counter holds the number of consecutive low samples. Any high sample clears it, so a change on `lps_i` before rising edge k affects the outputs after edge k+2.
- R3: With a low count of at least RST_THRESH and below DIS_THRESH, the state is reset (`state_o` = 2'b01).
- R4: With a low count below RST_THRESH, the state is active (`state_o` = 2'b00), `ctl_o`/`data_o`/`lreq_o` follow `ctl_i`/`data_i`/`lreq_i`, and `pclk_en_o` is 1.
- R5: In the reset state, `ctl_o`, `data_o` and `lreq_o` are 0 and `pclk_en_o` stays 1.
- R6: With a low count equal to DIS_THRESH, the state is disabled, `pclk_en_o` is 0, and the gated outputs are 0.
- R7: `link_active_o` is 1 exactly when the state is active and `lctrl_i` is 1.
- R8: `bus_rst_o` is a one-cycle pulse in the cycle the count is cleared from DIS_THRESH. Leaving the reset state for active produces no pulse.
- R9: A pulse train whose low runs are shorter than RST_THRESH keeps the state active. A high lasting a single cycle is recognised and clears the count.
- R10: The low count saturates at DIS_THRESH, so the state stays disabled for any longer low run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lps_i | input | 1 | Link power status line, level or pulsed |
| lctrl_i | input | 1 | Link-control register bit |
| lreq_i | input | 1 | Request input from the link |
| ctl_i | input | 2 | Control value from the PHY core |
| data_i | input | DATA_W | Data value from the PHY core |
| lreq_o | output | 1 | Request forwarded to the PHY core, masked when not active |
| ctl_o | output | 2 | Gated control output toward the link |
| data_o | output | DATA_W | Gated data output toward the link |
| pclk_en_o | output | 1 | PHY clock enable |
| link_active_o | output | 1 | Link-active bit for self-identification |
| bus_rst_o | output | 1 | One-cycle bus-reset request |
| state_o | output | 2 | Interface state: 00 active, 01 reset, 10 disabled |

## Verification
The hardest case to reach is a single-cycle high arriving after the counter has saturated at the disabled threshold, immediately followed by another low run. Only that sequence shows that one sample both clears the count and fires the wake pulse, and that counting then restarts from zero.

The bench uses small thresholds (8 and 20) so it can reach this case. It sweeps the low-run length from 1 to past saturation and predicts every cycle's count from the run length. It then drives the single-cycle wake from a saturated count and checks the pulse cycle and the new count.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_ACTIVE   = 2'b00,
    LPM_RESET    = 2'b01,
    LPM_DISABLED = 2'b10
  } lpm_state_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer
  import lpm_pkg::*;
#(
  parameter int unsigned RST_THRESH = 256,
  parameter int unsigned DIS_THRESH = 2560,
  localparam int unsigned CNT_W = $clog2(DIS_THRESH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lps_s_i,
  output lpm_state_e state_o,
  output logic       wake_o
);
  localparam logic [CNT_W-1:0] RstLim = CNT_W'(RST_THRESH);
  localparam logic [CNT_W-1:0] DisLim = CNT_W'(DIS_THRESH);

  logic [CNT_W-1:0] cnt_q;

  // hardware reset starts saturated: disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= DisLim;
    else if (lps_s_i)         cnt_q <= '0;
    else if (cnt_q != DisLim) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q == DisLim)      state_o = LPM_DISABLED;
    else if (cnt_q >= RstLim) state_o = LPM_RESET;
    else                      state_o = LPM_ACTIVE;
  end

  assign wake_o = lps_s_i && (cnt_q == DisLim);

  a_r2_high_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lps_s_i |=> cnt_q == '0);
  a_r2_low_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lps_s_i && cnt_q != DisLim) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r10_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DisLim);
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lpm_state_e        state_i,
  input  logic              wake_i,
  input  logic              lctrl_i,
  input  logic              lreq_i,
  input  logic [1:0]        ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lreq_o,
  output logic [1:0]        ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pclk_en_o,
  output logic              link_active_o,
  output logic              bus_rst_o
);
  logic live;
  logic bus_rst_q;

  assign live          = (state_i == LPM_ACTIVE);
  assign lreq_o        = live & lreq_i;
  assign ctl_o         = live ? ctl_i : '0;
  assign data_o        = live ? data_i : '0;
  assign pclk_en_o     = (state_i != LPM_DISABLED);
  assign link_active_o = live & lctrl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rst_q <= 1'b0;
    else         bus_rst_q <= wake_i;
  end
  assign bus_rst_o = bus_rst_q;

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |=> !bus_rst_o);
  a_r8_from_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rst_o) |-> $past(state_i) == LPM_DISABLED);
  a_r7_needs_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_active_o |-> lctrl_i && pclk_en_o);
  a_r8_wake_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |-> state_i == LPM_ACTIVE);
endmodule

// File: rtl/link_pwr_mon.sv
module link_pwr_mon
  import lpm_pkg::*;
#(
  parameter int unsigned RST_THRESH = 256,
  parameter int unsigned DIS_THRESH = 2560,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lps_i,
  input  logic              lctrl_i,
  input  logic              lreq_i,
  input  logic [1:0]        ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lreq_o,
  output logic [1:0]        ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pclk_en_o,
  output logic              link_active_o,
  output logic              bus_rst_o,
  output logic [1:0]        state_o
);
  logic       lps_s;
  logic       wake;
  lpm_state_e state;

  lpm_sync #(.STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lps_i),
    .q_o    (lps_s)
  );

  lpm_low_timer #(
    .RST_THRESH (RST_THRESH),
    .DIS_THRESH (DIS_THRESH)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lps_s_i (lps_s),
    .state_o (state),
    .wake_o  (wake)
  );

  lpm_gate #(.DATA_W(DATA_W)) i_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .wake_i        (wake),
    .lctrl_i       (lctrl_i),
    .lreq_i        (lreq_i),
    .ctl_i         (ctl_i),
    .data_i        (data_i),
    .lreq_o        (lreq_o),
    .ctl_o         (ctl_o),
    .data_o        (data_o),
    .pclk_en_o     (pclk_en_o),
    .link_active_o (link_active_o),
    .bus_rst_o     (bus_rst_o)
  );

  assign state_o = state;

  a_r5_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'b00) |-> (ctl_o == '0 && data_o == '0 && !lreq_o && !link_active_o));
endmodule

// File: tb/test_link_pwr_mon.sv
module test_link_pwr_mon;
  localparam int RST_T = 8;
  localparam int DIS_T = 20;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lps = 1'b0, lctrl = 1'b0, lreq = 1'b0;
  logic [1:0]    ctl = '0;
  logic [DW-1:0] data = '0;
  logic          lreq_o, pclk_en, link_act, bus_rst;
  logic [1:0]    ctl_o, state;
  logic [DW-1:0] data_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  link_pwr_mon #(.RST_THRESH(RST_T), .DIS_THRESH(DIS_T), .DATA_W(DW)) i_link_pwr_mon (
    .clk_i(clk), .rst_ni(rst_n), .lps_i(lps), .lctrl_i(lctrl), .lreq_i(lreq),
    .ctl_i(ctl), .data_i(data), .lreq_o(lreq_o), .ctl_o(ctl_o), .data_o(data_o),
    .pclk_en_o(pclk_en), .link_active_o(link_act), .bus_rst_o(bus_rst), .state_o(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // full output check from an expected low count and pulse
  task automatic check_all(input int cnt, input bit pulse, input string tag);
    int st;
    bit live;
    st   = (cnt == DIS_T) ? 2 : (cnt >= RST_T) ? 1 : 0;
    live = (st == 0);
    chk({tag, " R3/R6 state"}, state, st);
    chk({tag, " R4/R6 pclk_en"}, pclk_en, st != 2);
    chk({tag, " R4/R5 ctl"}, ctl_o, live ? ctl : 0);
    chk({tag, " R4/R5 data"}, data_o, live ? data : 0);
    chk({tag, " R4/R5 lreq"}, lreq_o, live ? lreq : 0);
    chk({tag, " R7 link_active"}, link_act, live && lctrl);
    chk({tag, " R8 bus_rst"}, bus_rst, pulse);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ctl = 2'b11; data = 8'hA5; lreq = 1'b1; lctrl = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state is disabled
    chk("R1 state", state, 2);
    chk("R1 pclk_en", pclk_en, 0);
    chk("R1 ctl", ctl_o, 0);
    chk("R1 data", data_o, 0);
    chk("R1 lreq", lreq_o, 0);
    chk("R1 link_active", link_act, 0);
    // R2/R8: first high after reset -> pulse after third edge
    lps = 1'b1;
    tick(); chk("R2 no early pulse e1", bus_rst, 0);
    tick(); chk("R2 no early pulse e2", bus_rst, 0); chk("R2 still disabled", state, 2);
    tick(); chk("R8 wake pulse", bus_rst, 1); chk("R2 active after e3", state, 0);
    tick(); chk("R8 pulse one cycle", bus_rst, 0);

    // R2..R10 sweep of low-run length L
    for (int L = 1; L <= DIS_T + 3; L++) begin
      lps = 1'b1;
      repeat (5) tick();
      ctl = 2'(L); data = 8'(L * 37 + 3); lreq = L[1]; lctrl = L[0];
      lps = 1'b0;
      for (int m = 1; m <= L + 4; m++) begin
        int c;
        if (m == L + 1) lps = 1'b1;
        tick();
        if (m <= 2)          c = 0;
        else if (m <= L + 2) c = (m - 2 < DIS_T) ? m - 2 : DIS_T;  // R10
        else                 c = 0;
        check_all(c, (m == L + 3) && (L >= DIS_T), "sweep");
      end
    end

    // R9: pulse train, low runs of RST_T-2, single-cycle highs
    lps = 1'b1; repeat (5) tick();
    ctl = 2'b10; data = 8'h3C; lreq = 1'b1; lctrl = 1'b1;
    for (int p = 0; p < 8; p++) begin
      lps = 1'b0;
      repeat (RST_T - 2) begin tick(); chk("R9 train active", state, 0); end
      lps = 1'b1;
      tick(); chk("R9 train active", state, 0); chk("R9 train link_active", link_act, 1);
    end

    // R9/R8: single-cycle high from a saturated count, then low again
    lps = 1'b0;
    repeat (DIS_T + 10) tick();
    chk("R10 held disabled", state, 2);
    lps = 1'b1; tick();     // edge h
    lps = 1'b0; tick();     // edge h+1
    chk("R8 no pulse yet", bus_rst, 0);
    tick();                 // edge h+2
    check_all(0, 1'b1, "R9 single high wake");
    for (int k = 1; k <= RST_T; k++) begin
      tick();
      check_all(k, 1'b0, "R9 recount");
    end

    // R8: reset -> active gives no pulse
    lps = 1'b1;
    repeat (3) tick();
    chk("R8 no pulse from reset state", bus_rst, 0);
    tick(); chk("R8 no pulse from reset state", bus_rst, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule